// File: doc/BRIEF.md
# Byte-Stream FPGA Configuration Loader

This block takes a configuration image one byte at a time over a valid/ready stream and loads it into a target FPGA through that device's byte-wide slave-parallel configuration port. Leading bytes are discarded until a run of four consecutive 0xFF bytes is seen. That header starts the load. The header and every byte after it are then written to the target. Each byte is bit-reversed and clocked out with a slow three-phase pulse on the configuration clock.

Before any data is written, the loader steps the target through its program, INIT and select sequence. After the stream's last byte it deselects the target, releases write, and samples DONE. It then raises a one-cycle end pulse carrying exactly one outcome flag and the number of bytes written. The port pins leave the block as a single 16-bit control word whose bit positions match the board's programming register.

Top module: `cfg_byte_loader`

## Requirements
- R1: While hunting, input bytes are accepted and dropped until four consecutive SYNC_BYTE (0xFF) bytes arrive. Any other byte restarts the run. The four header bytes and all later bytes are written to the target, in input order.
- R2: The load ends with `fail_sync_o` set, and chip select never goes low, in two cases: SYNC_WIN input bytes (default 256) have been taken without a complete header, or a byte marked last arrives before the header is complete. A header completed on exactly the SYNC_WIN-th byte still starts a load.
- R3: Each written byte is bit-reversed, so input bit i appears on data line 7-i.
- R4: The start sequence runs in this order. First, select is held high with program low for SETUP_CYC cycles. Then program rises, and stays high for at least SETUP_CYC cycles. Then the block waits for `init_i` high. Then write rises. After that, select falls.
- R5: Each byte is clocked out as clock low, clock high, clock low, with each phase lasting HALF_CYC cycles. Data stays constant across all three phases.
- R6: Control word layout: bit 15 write, bit 14 program, bit 13 configuration clock, bit 8 active-low select, bits 7..0 data. Bits 12..9 are always 0. After reset the word is 0x0100.
- R7: Stop sequence: select rises with the clock low and write still high. Write falls on a later cycle.
- R8: After the stop sequence, `done_i` is sampled. High sets `ok_o`; low sets `fail_done_o`.
- R9: At the end pulse, `bytes_o` holds the count of bytes written to the target, header included. It holds 0 for a load that was aborted.
- R10: `ready_o` is low while the block waits through the start sequence and while the configuration clock is high. No accepted byte is lost.
- R11: If `init_i` stays low for INIT_TMO cycles, the load ends with `fail_init_o`, and the word returns to 0x0100.
- R12: `end_o` lasts one cycle. While it is high, exactly one of `ok_o`, `fail_sync_o`, `fail_init_o` or `fail_done_o` is set. The flags hold until the next end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Stream byte |
| valid_i | input | 1 | Stream byte valid |
| last_i | input | 1 | Marks the final byte of the stream |
| ready_o | output | 1 | Block accepts the stream byte |
| cfg_word_o | output | 16 | Configuration port control word |
| init_i | input | 1 | Target INIT status |
| done_i | input | 1 | Target DONE status |
| end_o | output | 1 | One-cycle end-of-load pulse |
| ok_o | output | 1 | Configuration succeeded |
| fail_sync_o | output | 1 | No sync header found |
| fail_init_o | output | 1 | INIT wait timed out |
| fail_done_o | output | 1 | DONE low after the stop sequence |
| bytes_o | output | CNT_W | Bytes written in the last load |

## Verification
The bench builds the loader with SYNC_WIN=16, SETUP_CYC=3, HALF_CYC=2 and INIT_TMO=40. The short window makes the abort boundary, and a header that completes exactly on the last byte of the window, reachable in a few dozen bytes. The two-cycle half period makes the per-phase length measurable, and the short INIT timeout lets the stalled-INIT path finish quickly. A behavioural target model captures the data on each rising clock edge while select is low, drives INIT after a delay once program is asserted, and returns a DONE level chosen per test.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WR_BIT   = 15;
  localparam int PROG_BIT = 14;
  localparam int CCLK_BIT = 13;
  localparam int CS_BIT   = 8;

  typedef enum logic [3:0] {
    S_HUNT, S_CS_HOLD, S_PROG, S_INIT, S_WR_ON, S_SEL, S_FEED,
    S_PH0, S_PH1, S_PH2, S_STOP_CS, S_STOP_WR, S_CHECK, S_FIN
  } ld_state_e;
endpackage

// File: rtl/cfg_bit_rev.sv
module cfg_bit_rev #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign out_o[i] = in_i[W-1-i];
  end
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_sync_hunt.sv
module cfg_sync_hunt #(
  parameter logic [7:0] SYNC_BYTE = 8'hFF,
  parameter int         HDR_LEN   = 4,
  parameter int         WIN       = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       take_i,
  input  logic [7:0] byte_i,
  output logic       found_o,
  output logic       exhaust_o
);
  localparam int RUN_W  = $clog2(HDR_LEN + 1);
  localparam int SEEN_W = $clog2(WIN + 1);

  logic [RUN_W-1:0]  run_q;
  logic [SEEN_W-1:0] seen_q;
  logic              is_sync;

  assign is_sync   = (byte_i == SYNC_BYTE);
  assign found_o   = take_i && is_sync && (run_q == RUN_W'(HDR_LEN - 1));
  assign exhaust_o = take_i && !found_o && (seen_q == SEEN_W'(WIN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      seen_q <= '0;
    end else if (clear_i) begin
      run_q  <= '0;
      seen_q <= '0;
    end else if (take_i) begin
      run_q  <= (is_sync && !found_o) ? run_q + 1'b1 : '0;
      seen_q <= seen_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_byte_loader.sv
module cfg_byte_loader
  import cfg_loader_pkg::*;
#(
  parameter int         SETUP_CYC = 30,
  parameter int         HALF_CYC  = 1,
  parameter int         INIT_TMO  = 100000,
  parameter int         SYNC_WIN  = 256,
  parameter int         HDR_LEN   = 4,
  parameter logic [7:0] SYNC_BYTE = 8'hFF,
  parameter int         CNT_W     = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       byte_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic             ready_o,
  output logic [15:0]      cfg_word_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             end_o,
  output logic             ok_o,
  output logic             fail_sync_o,
  output logic             fail_init_o,
  output logic             fail_done_o,
  output logic [CNT_W-1:0] bytes_o
);
  localparam int T_A   = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int T_MAX = (T_A > INIT_TMO) ? T_A : INIT_TMO;
  localparam int TMR_W = $clog2(T_MAX + 1);
  localparam int HL_W  = $clog2(HDR_LEN + 1);

  ld_state_e        st_q, st_d;
  logic             wr_q, prog_q, cclk_q, cs_q, last_q;
  logic [7:0]       data_q, rev_byte, sync_rev;
  logic [HL_W-1:0]  hdr_left_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tz, tmr_load, found, exhaust, hunt_take;
  logic [TMR_W-1:0] tmr_val;

  cfg_bit_rev #(.W(8)) u_rev_in  (.in_i(byte_i),    .out_o(rev_byte));
  cfg_bit_rev #(.W(8)) u_rev_hdr (.in_i(SYNC_BYTE), .out_o(sync_rev));

  assign hunt_take = (st_q == S_HUNT) && valid_i;

  cfg_sync_hunt #(.SYNC_BYTE(SYNC_BYTE), .HDR_LEN(HDR_LEN), .WIN(SYNC_WIN)) u_hunt (
    .clk_i, .rst_ni,
    .clear_i  (st_q != S_HUNT),
    .take_i   (hunt_take),
    .byte_i,
    .found_o  (found),
    .exhaust_o(exhaust)
  );

  cfg_wait_timer #(.W(TMR_W)) u_tmr (
    .clk_i, .rst_ni,
    .load_i(tmr_load),
    .val_i (tmr_val),
    .zero_o(tz)
  );

  assign ready_o = (st_q == S_HUNT) || (st_q == S_FEED);

  always_comb begin
    ld_state_e after_byte;
    after_byte = (hdr_left_q != '0) ? S_PH0 : (last_q ? S_STOP_CS : S_FEED);
    st_d = st_q;
    unique case (st_q)
      S_HUNT:    if (hunt_take) begin
                   if (found)                   st_d = S_CS_HOLD;
                   else if (exhaust || last_i)  st_d = S_FIN;
                 end
      S_CS_HOLD: if (tz) st_d = S_PROG;
      S_PROG:    if (tz) st_d = S_INIT;
      S_INIT:    if (init_i) st_d = S_WR_ON;
                 else if (tz) st_d = S_FIN;
      S_WR_ON:   st_d = S_SEL;
      S_SEL:     st_d = S_PH0;
      S_FEED:    if (valid_i) st_d = S_PH0;
      S_PH0:     if (tz) st_d = S_PH1;
      S_PH1:     if (tz) st_d = S_PH2;
      S_PH2:     if (tz) st_d = after_byte;
      S_STOP_CS: st_d = S_STOP_WR;
      S_STOP_WR: st_d = S_CHECK;
      S_CHECK:   st_d = S_FIN;
      S_FIN:     st_d = S_HUNT;
      default:   st_d = S_HUNT;
    endcase
  end

  // timer reloads on every state change; waits last (value + 1) cycles
  assign tmr_load = (st_d != st_q) || (st_q == S_PH2 && st_d == S_PH0);
  always_comb begin
    unique case (st_d)
      S_CS_HOLD, S_PROG:   tmr_val = TMR_W'(SETUP_CYC - 1);
      S_INIT:              tmr_val = TMR_W'(INIT_TMO - 1);
      S_PH0, S_PH1, S_PH2: tmr_val = TMR_W'(HALF_CYC - 1);
      default:             tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_HUNT;
      {wr_q, prog_q, cclk_q, last_q} <= '0;
      cs_q        <= 1'b1;
      data_q      <= '0;
      hdr_left_q  <= '0;
      cnt_q       <= '0;
      end_o       <= 1'b0;
      ok_o        <= 1'b0;
      fail_sync_o <= 1'b0;
      fail_init_o <= 1'b0;
      fail_done_o <= 1'b0;
      bytes_o     <= '0;
    end else begin
      st_q  <= st_d;
      end_o <= (st_d == S_FIN);
      if (st_d == S_FIN) begin
        ok_o        <= (st_q == S_CHECK) && done_i;
        fail_done_o <= (st_q == S_CHECK) && !done_i;
        fail_sync_o <= (st_q == S_HUNT);
        fail_init_o <= (st_q == S_INIT);
        bytes_o     <= (st_q == S_CHECK) ? cnt_q : '0;
      end
      unique case (st_d)
        S_CS_HOLD: if (st_q == S_HUNT) begin
          {wr_q, prog_q, cclk_q} <= '0;
          cs_q   <= 1'b1;
          data_q <= '0;
          cnt_q  <= '0;
          last_q <= last_i;
        end
        S_PROG:  prog_q <= 1'b1;
        S_WR_ON: wr_q   <= 1'b1;
        S_SEL: begin
          cs_q       <= 1'b0;
          hdr_left_q <= HL_W'(HDR_LEN);
        end
        S_PH0: if (st_q == S_FEED) begin
          data_q <= rev_byte;
          last_q <= last_i;
          cnt_q  <= cnt_q + 1'b1;
        end else if (st_q != S_PH0) begin
          data_q     <= sync_rev;
          hdr_left_q <= hdr_left_q - 1'b1;
          cnt_q      <= cnt_q + 1'b1;
        end
        S_PH1: cclk_q <= 1'b1;
        S_PH2: cclk_q <= 1'b0;
        S_STOP_CS: begin
          cs_q   <= 1'b1;
          cclk_q <= 1'b0;
        end
        S_STOP_WR: wr_q <= 1'b0;
        S_FIN: if (st_q == S_INIT) begin
          {wr_q, prog_q} <= '0;
          cs_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_word_o           = '0;
    cfg_word_o[WR_BIT]   = wr_q;
    cfg_word_o[PROG_BIT] = prog_q;
    cfg_word_o[CCLK_BIT] = cclk_q;
    cfg_word_o[CS_BIT]   = cs_q;
    cfg_word_o[7:0]      = data_q;
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_loader_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ready_o,
  input logic [15:0] cfg_word_o,
  input logic        end_o,
  input logic        ok_o,
  input logic        fail_sync_o,
  input logic        fail_init_o,
  input logic        fail_done_o
);
  a_r4_select_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_word_o[CS_BIT] |-> (cfg_word_o[WR_BIT] && cfg_word_o[PROG_BIT]));

  a_r5_data_held_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_word_o[CCLK_BIT]) |-> $stable(cfg_word_o[7:0]));

  a_r5_data_held_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_word_o[CCLK_BIT]) |-> $stable(cfg_word_o[7:0]));

  a_r7_write_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_word_o[WR_BIT]) |-> (cfg_word_o[CS_BIT] && $past(cfg_word_o[CS_BIT])));

  a_r10_no_ready_in_clock_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_word_o[CCLK_BIT] |-> !ready_o);

  a_r12_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> ($countones({ok_o, fail_sync_o, fail_init_o, fail_done_o}) == 1));

  a_r12_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !end_o);
endmodule

bind cfg_byte_loader cfg_loader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .cfg_word_o (cfg_word_o),
  .end_o      (end_o),
  .ok_o       (ok_o),
  .fail_sync_o(fail_sync_o),
  .fail_init_o(fail_init_o),
  .fail_done_o(fail_done_o)
);

// File: tb/cfg_byte_loader_test.sv
`timescale 1ns/1ps
module cfg_byte_loader_test;
  localparam int SETUP = 3, HALF = 2, TMO = 40, WIN = 16, CW = 16, INIT_DLY = 5;

  typedef struct packed {
    logic [7:0] junk;
    logic       mode;
    logic [7:0] plen;
    logic [7:0] seed;
    logic       done;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{8'd0,  1'b0, 8'd6, 8'h01, 1'b1},
    '{8'd5,  1'b0, 8'd3, 8'h80, 1'b1},
    '{8'd8,  1'b1, 8'd4, 8'h13, 1'b0},
    '{8'd12, 1'b0, 8'd2, 8'hF0, 1'b1},
    '{8'd3,  1'b0, 8'd0, 8'h00, 1'b1}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] byte_i = '0;
  logic valid_i = 1'b0, last_i = 1'b0, init_i = 1'b0, done_i = 1'b0;
  logic ready_o, end_o, ok_o, fail_sync_o, fail_init_o, fail_done_o;
  logic [15:0] cfg_word_o;
  logic [CW-1:0] bytes_o;

  cfg_byte_loader #(.SETUP_CYC(SETUP), .HALF_CYC(HALF), .INIT_TMO(TMO),
                    .SYNC_WIN(WIN), .CNT_W(CW)) uut (.*);

  always #5 clk_i = ~clk_i;

  int nchk = 0, nerr = 0, cyc = 0;
  logic [7:0] cap [64];
  int cap_n = 0, hi_run = 0, phase_bad = 0, rdy_bad = 0, rsv_bad = 0, cs_low_seen = 0;
  int t_sync, t_prog, t_init, t_wr, t_csf, t_csr, t_wrf, init_cnt = 0;
  logic init_block = 1'b0, stop_bad = 1'b0;
  logic [15:0] pw = 16'h0100;
  bit fin = 0;

  task automatic check(input bit c, input string tag, input int act, input int exp);
    nchk++;
    if (!c) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] flip(input logic [7:0] x);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = x[7-k];
    return r;
  endfunction

  // target model and port monitor
  always @(negedge clk_i) begin
    cyc++;
    if (cfg_word_o[12:9] != 4'd0) rsv_bad++;
    if (cfg_word_o[13] && ready_o) rdy_bad++;
    if (!cfg_word_o[8]) cs_low_seen++;
    if (cfg_word_o[13]) hi_run++;
    if (cfg_word_o[13] && !pw[13] && !cfg_word_o[8] && cfg_word_o[15] && cap_n < 64) begin
      cap[cap_n] = cfg_word_o[7:0];
      cap_n++;
    end
    if (!cfg_word_o[13] && pw[13]) begin
      if (hi_run != HALF) phase_bad++;
      hi_run = 0;
    end
    if (cfg_word_o[14] && !pw[14]) t_prog = cyc;
    if (cfg_word_o[15] && !pw[15]) t_wr = cyc;
    if (!cfg_word_o[15] && pw[15]) t_wrf = cyc;
    if (!cfg_word_o[8] && pw[8]) t_csf = cyc;
    if (cfg_word_o[8] && !pw[8]) begin
      t_csr = cyc;
      if (cfg_word_o[13] || !cfg_word_o[15]) stop_bad = 1'b1;
    end
    pw = cfg_word_o;
    if (!cfg_word_o[14]) begin
      init_i = 1'b0;
      init_cnt = 0;
    end else if (!init_block) begin
      init_cnt++;
      if (init_cnt >= INIT_DLY && !init_i) begin
        init_i = 1'b1;
        t_init = cyc;
      end
    end
  end

  task automatic push(input logic [7:0] b, input logic l);
    @(negedge clk_i);
    byte_i = b; last_i = l; valid_i = 1'b1;
    while (!ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1 valid_i = 1'b0; last_i = 1'b0;
  endtask

  task automatic wait_end();
    @(negedge clk_i);
    while (!end_o) @(negedge clk_i);
  endtask

  task automatic run_vec(input vec_t v);
    int np;
    cap_n = 0; done_i = v.done; stop_bad = 1'b0;
    for (int j = 0; j < int'(v.junk); j++)
      push(v.mode ? ((j % 4 == 3) ? 8'h00 : 8'hFF) : (8'h3C ^ 8'(j)), 1'b0);
    for (int h = 0; h < 4; h++) begin
      push(8'hFF, (h == 3) && (v.plen == 8'd0));
      if (h == 3) t_sync = cyc;
    end
    for (int p = 0; p < int'(v.plen); p++)
      push(v.seed + 8'(p * 37), p == int'(v.plen) - 1);
    wait_end();
    np = 4 + int'(v.plen);
    check(cap_n == np, "R1 written byte count", cap_n, np);
    for (int i = 0; i < np && i < cap_n; i++) begin
      logic [7:0] e;
      e = (i < 4) ? 8'hFF : flip(v.seed + 8'(((i - 4) * 37)));
      check(cap[i] == e, (i < 4) ? "R1 header byte" : "R3 reversed data", int'(cap[i]), int'(e));
    end
    check(int'(bytes_o) == np, "R9 bytes_o", int'(bytes_o), np);
    check(ok_o == v.done && fail_done_o == !v.done, "R8 done outcome", int'({ok_o, fail_done_o}),
          int'({v.done, !v.done}));
    check(t_prog - t_sync >= SETUP && t_wr - t_prog >= SETUP, "R4 setup gaps",
          t_wr - t_prog, SETUP);
    check(t_wr > t_init && t_csf > t_wr, "R4 init-write-select order", t_csf - t_wr, 1);
    check(!stop_bad && t_wrf > t_csr, "R7 stop order", t_wrf - t_csr, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cfg_word_o == 16'h0100, "R6 reset word", int'(cfg_word_o), 16'h0100);
    check(ready_o && !end_o, "R12 reset idle", int'({ready_o, end_o}), 2);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R2 window exhausted with no header
    cs_low_seen = 0;
    for (int j = 0; j < WIN; j++) push(8'h11, 1'b0);
    wait_end();
    check(fail_sync_o && !ok_o, "R2 window abort", int'(fail_sync_o), 1);
    check(int'(bytes_o) == 0 && cs_low_seen == 0, "R2 nothing written", int'(bytes_o), 0);

    // R2 stream ends before header complete
    push(8'hFF, 1'b0); push(8'hFF, 1'b0); push(8'hFF, 1'b1);
    wait_end();
    check(fail_sync_o && cs_low_seen == 0, "R2 early last", int'(fail_sync_o), 1);

    // R11 INIT never rises
    init_block = 1'b1;
    for (int h = 0; h < 4; h++) push(8'hFF, 1'b0);
    wait_end();
    check(fail_init_o && !ok_o, "R11 init timeout", int'(fail_init_o), 1);
    check(int'(bytes_o) == 0, "R11 no bytes", int'(bytes_o), 0);
    @(negedge clk_i);
    check(cfg_word_o == 16'h0100, "R11 word released", int'(cfg_word_o), 16'h0100);
    check(!end_o, "R12 pulse width", int'(end_o), 0);
    init_block = 1'b0;

    check(phase_bad == 0, "R5 clock phase length", phase_bad, 0);
    check(rdy_bad == 0, "R10 ready during clock high", rdy_bad, 0);
    check(rsv_bad == 0, "R6 reserved bits", rsv_bad, 0);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  always @(negedge clk_i) begin
    if (!fin && cyc > 100000) begin
      fin = 1;
      nchk++; nerr++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule